// File: doc/BRIEF.md
# Byte-Wide I/O Bus Master

This block sits between a processor core and a narrow, multiplexed peripheral bus. The bus has one 8-bit data path and one mode-select line. When the core raises a start request, the block stores a 16-bit port address, a write byte and a direction flag. It then walks the bus through five phases, one clock cycle each:

- A priming cycle, with mode-select high.
- The address high byte.
- The address low byte.
- One data cycle.
- A completion cycle, in which a one-cycle done strobe is raised.

The direction of a transfer is signalled by the mode-select line. After priming, it stays high for the high-byte cycle only on a write. On a read it stays high for both address cycles. On a write, the block drives the stored byte during the data cycle. On a read, the block releases the bus and captures the peer's byte at the end of the data cycle. That byte is presented with the done strobe.

The bus pins are split into separate output, output-enable and input ports. An external pad ring or tri-state buffer combines them into one bidirectional wire.

Top module: `byte_io_master`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state is idle: `bus_ms`, `bus_oe`, `busy` and `done` are 0, and `rd_data` is 0x00.
- R2: A `start` seen high in idle makes the following cycle the priming cycle. In the priming cycle `bus_ms`=1, `bus_oe`=0 and `busy`=1.
- R3: The cycle after priming drives bits [15:8] of the stored address on `bus_out`, with `bus_oe`=1 and `bus_ms`=1.
- R4: The next cycle drives bits [7:0] of the stored address with `bus_oe`=1. In this cycle `bus_ms` is 1 for a read (`rd_nwr`=1) and 0 for a write (`rd_nwr`=0).
- R5: In the data cycle of a write, `bus_out` carries the stored write byte with `bus_oe`=1 and `bus_ms`=0.
- R6: In the data cycle of a read, `bus_oe`=0 and `bus_ms`=0, and `bus_in` is sampled at the end of that cycle.
- R7: `done` is high for exactly the one cycle after the data cycle. On a read, `rd_data` then equals the sampled byte. On a write, `rd_data` keeps its previous value.
- R8: `busy` is high from the priming cycle through the data cycle. A `start` seen while `busy` is high is ignored and begins no further transfer.
- R9: Address, write byte and direction are stored when a transfer is accepted. Changes on those inputs during the transfer have no effect on the bus.
- R10: A `start` raised in the cycle where `done` is high is accepted, and the next cycle is a priming cycle.
- R11: `bus_oe` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the core side and the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a transfer (accepted only when idle) |
| rd_nwr | input | 1 | Direction: 1 read, 0 write |
| port_addr | input | 16 | Peripheral port address |
| wr_data | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | 8 | Captured read byte |
| bus_ms | output | 1 | Bus mode-select line |
| bus_out | output | 8 | Byte driven onto the bus |
| bus_oe | output | 1 | Output enable for `bus_out` |
| bus_in | input | 8 | Byte sampled from the bus |

## Verification
The hardest case to reach from the ports is a second request that arrives while a transfer is already in flight. That request carries different address, data and direction values. It must neither restart the sequence nor leak into the stored fields.

The bench raises `start` during the priming cycle. At the same moment it inverts every request input. It then checks each bus phase against the original request, and checks that the bus returns to idle after completion. A separate scenario raises `start` exactly in the done cycle to cover the back-to-back acceptance edge.

// File: rtl/byte_io_pkg.sv
// Package: shared phase encoding for the byte-wide I/O bus master.
// Assumes one bus phase per clock cycle.
package byte_io_pkg;
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PRIME = 3'd1,
        PH_AHI   = 3'd2,
        PH_ALO   = 3'd3,
        PH_DATA  = 3'd4
    } phase_e;
endpackage

// File: rtl/bio_sequencer.sv
// Phase sequencer: accepts a request while idle, stores its fields and
// steps through prime, address-high, address-low and data phases.
// Assumes start is ignored in any phase other than idle.
module bio_sequencer
    import byte_io_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [DATA_W-1:0] wr_data,
    output phase_e            phase,
    output logic              dir_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdat_q
);
    phase_e phase_n;

    // Next-phase selection.
    always_comb begin
        unique case (phase)
            PH_IDLE:  phase_n = start ? PH_PRIME : PH_IDLE;
            PH_PRIME: phase_n = PH_AHI;
            PH_AHI:   phase_n = PH_ALO;
            PH_ALO:   phase_n = PH_DATA;
            default:  phase_n = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_n;
    end

    // Request field storage, loaded only on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            addr_q <= '0;
            wdat_q <= '0;
        end else if (phase == PH_IDLE && start) begin
            dir_q  <= rd_nwr;
            addr_q <= port_addr;
            wdat_q <= wr_data;
        end
    end

    // R2
    prime_then_ahi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PRIME) |=> (phase == PH_AHI));

    // R9
    fields_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> ($stable(addr_q) && $stable(wdat_q) && $stable(dir_q)));
endmodule

// File: rtl/bio_driver.sv
// Bus driver: selects the byte, mode-select level and output enable for
// the current phase. Purely combinational; assumes the stored request fields.
module bio_driver
    import byte_io_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  phase_e            phase,
    input  logic              dir_q,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdat_q,
    output logic              bus_ms,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);
    logic [DATA_W-1:0] addr_hi;
    logic [DATA_W-1:0] addr_lo;

    // Address byte split, high byte first.
    always_comb begin
        addr_hi = addr_q[ADDR_W-1:DATA_W];
        addr_lo = addr_q[DATA_W-1:0];
    end

    // Per-phase byte, mode-select and enable.
    always_comb begin
        bus_ms  = 1'b0;
        bus_oe  = 1'b0;
        bus_out = '0;
        unique case (phase)
            PH_PRIME: bus_ms = 1'b1;
            PH_AHI: begin
                bus_ms  = 1'b1;
                bus_oe  = 1'b1;
                bus_out = addr_hi;
            end
            PH_ALO: begin
                bus_ms  = dir_q;
                bus_oe  = 1'b1;
                bus_out = addr_lo;
            end
            PH_DATA: begin
                bus_oe  = !dir_q;
                bus_out = dir_q ? '0 : wdat_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bio_capture.sv
// Read capture: samples the bus at the end of a read data phase and
// raises a one-cycle done strobe after every data phase.
module bio_capture
    import byte_io_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              dir_q,
    input  logic [DATA_W-1:0] bus_in,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);
    // Completion strobe and read-byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= (phase == PH_DATA);
            if (phase == PH_DATA && dir_q) rd_data <= bus_in;
        end
    end

    // R6
    read_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA && dir_q) |=> (rd_data == $past(bus_in)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/byte_io_master.sv
// Top: byte-wide multiplexed I/O bus master. Sends a 16-bit port address
// as two bytes after a priming phase, then writes or reads one byte.
// Assumes an external buffer merges bus_out/bus_oe/bus_in into one wire.
module byte_io_master
    import byte_io_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_nwr,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              bus_ms,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_in
);
    phase_e            phase;
    logic              dir_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdat_q;

    bio_sequencer #(.DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .port_addr(port_addr), .wr_data(wr_data),
        .phase(phase), .dir_q(dir_q), .addr_q(addr_q), .wdat_q(wdat_q)
    );

    bio_driver #(.DATA_W(DATA_W)) u_drv (
        .phase(phase), .dir_q(dir_q), .addr_q(addr_q), .wdat_q(wdat_q),
        .bus_ms(bus_ms), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    bio_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .phase(phase), .dir_q(dir_q),
        .bus_in(bus_in), .done(done), .rd_data(rd_data)
    );

    // Busy flag: any non-idle phase.
    always_comb busy = (phase != PH_IDLE);

    // R11
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_oe);

    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && phase != PH_DATA && start) |=> busy);
endmodule

// File: tb/tb_byte_io_master.sv
module tb_byte_io_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_nwr = 1'b0;
    logic [15:0] port_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        busy, done, bus_ms, bus_oe;
    logic [7:0]  rd_data, bus_out;
    logic [7:0]  bus_in = '0;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_rd = 8'h00;

    always #4 clk = ~clk;

    byte_io_master dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_nwr(rd_nwr),
        .port_addr(port_addr), .wr_data(wr_data), .busy(busy), .done(done),
        .rd_data(rd_data), .bus_ms(bus_ms), .bus_out(bus_out),
        .bus_oe(bus_oe), .bus_in(bus_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        step();
        step();
        chk({bus_ms, bus_oe, busy, done} == 4'b0, "R1 ctrl",
            {bus_ms, bus_oe, busy, done}, 0);
        chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
        rst_n = 1'b1;
        step();
    endtask

    // Present a request at the current negedge.
    task automatic req(input bit rd, input logic [15:0] a, input logic [7:0] wd);
        start = 1'b1;
        rd_nwr = rd;
        port_addr = a;
        wr_data = wd;
    endtask

    // Walk one accepted transfer; leaves at the negedge of the done cycle.
    task automatic walk(input bit rd, input logic [15:0] a, input logic [7:0] wd,
                        input logic [7:0] rv, input bit poke);
        step();
        start = 1'b0;
        chk(bus_ms && !bus_oe && busy, "R2 prime", {bus_ms, bus_oe, busy}, 3'b101);
        if (poke) begin
            // R8 R9: second request with inverted fields while busy
            req(!rd, ~a, ~wd);
        end
        step();
        start = 1'b0;
        port_addr = 16'h0000;
        chk(bus_ms && bus_oe && bus_out == a[15:8], "R3 addr hi",
            {bus_ms, bus_oe, bus_out}, {2'b11, a[15:8]});
        step();
        chk(bus_ms == rd && bus_oe && bus_out == a[7:0], "R4 addr lo",
            {bus_ms, bus_oe, bus_out}, {rd, 1'b1, a[7:0]});
        step();
        if (rd) begin
            chk(!bus_ms && !bus_oe && busy, "R6 read data phase",
                {bus_ms, bus_oe, busy}, 3'b001);
            bus_in = rv;
            exp_rd = rv;
        end else begin
            chk(!bus_ms && bus_oe && bus_out == wd, "R5 write data phase",
                {bus_ms, bus_oe, bus_out}, {2'b01, wd});
            bus_in = ~rv;
        end
        step();
        bus_in = 8'h00;
        chk(done && !busy, "R7 done strobe", {done, busy}, 2'b10);
        chk(rd_data == exp_rd, "R7 rd_data", rd_data, exp_rd);
    endtask

    // R8 R11: block returns to and stays in idle
    task automatic t_idle(input string tag);
        step();
        chk(!done && !busy && !bus_ms && !bus_oe, tag,
            {done, busy, bus_ms, bus_oe}, 0);
    endtask

    task automatic t_write();
        req(1'b0, 16'hA53C, 8'h96);
        walk(1'b0, 16'hA53C, 8'h96, 8'h11, 1'b0);
        t_idle("R11 idle after write");
    endtask

    task automatic t_read();
        req(1'b1, 16'h1234, 8'hFF);
        walk(1'b1, 16'h1234, 8'hFF, 8'hC7, 1'b0);
        t_idle("R11 idle after read");
    endtask

    task automatic t_poke();
        req(1'b1, 16'h80F1, 8'h5A);
        walk(1'b1, 16'h80F1, 8'h5A, 8'h3E, 1'b1);
        t_idle("R8 no restart after busy start");
        req(1'b0, 16'h00FF, 8'h01);
        walk(1'b0, 16'h00FF, 8'h01, 8'h77, 1'b1);
        t_idle("R8 no restart after busy start wr");
    endtask

    task automatic t_b2b();
        req(1'b0, 16'h4242, 8'hE0);
        walk(1'b0, 16'h4242, 8'hE0, 8'h00, 1'b0);
        // R10: start in done cycle
        req(1'b1, 16'hFFFE, 8'h00);
        walk(1'b1, 16'hFFFE, 8'h00, 8'hA1, 1'b0);
        t_idle("R10 idle after back-to-back");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle("R11 idle without start");
        t_write();
        t_read();
        t_poke();
        t_b2b();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule